// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

This block turns a serial bit stream into a parallel word. It holds the word until software or a sequencer decides to publish it. The block has two stages. A chain of shift stages takes one bit per rising edge of a shift strobe. A separate storage register copies the whole chain on a rising edge of a store strobe and drives the parallel outputs. Because the copy step is separate, the parallel outputs stay quiet while a new word is being shifted in. The last stage is also brought out as a cascade bit, so several instances can be chained into a wider register.

Both strobes are level inputs sampled on the system clock, and the block reacts to their low-to-high transitions. An active-low clear empties the shift stages and leaves the stored word alone. An active-low output enable either lets the stored word reach the parallel pins or parks them. When parked, the data pins read zero and a per-bit drive-enable vector drops low, so the pad ring can place the pins in high impedance.

Top module: `ser_latch_sreg`

## Requirements
- R1: A rising transition of `shift_clk` while `clr_n` is high loads `ser_in` into stage 0 and moves every stage n to the old value of stage n-1. Stage n appears on bit n of the parallel word after a store, so a byte sent most-significant bit first reads back unchanged.
- R2: A rising transition of `store_clk` while `clr_n` is high copies all shift stages into the storage register.
- R3: While `clr_n` is low, all shift stages become zero one clock later, and the storage register keeps its value.
- R4: `casc_out` is low, with no clock delay, whenever `clr_n` is low.
- R5: A rising transition of `store_clk` while `clr_n` is low loads all zeros into the storage register.
- R6: When `oe_n` is low, `par_q` equals the storage register and `par_en` is all ones. When `oe_n` is high, `par_q` is all zeros and `par_en` is all zeros.
- R7: With `clr_n` high, `casc_out` equals the last shift stage. After a shift it shows the value the second-to-last stage held before the shift. `oe_n` has no effect on it.
- R8: When both strobes rise in the same clock, the storage register captures the shift contents from before that shift.
- R9: A `shift_clk` rising transition while `clr_n` is low has no effect, so the stages stay zero after the clear is released.
- R10: A store alone never changes the shift stages, and a shift alone never changes the parallel outputs.
- R11: After synchronous reset (`rst_n` low at a clock edge), the shift stages and the storage register are zero.
- R12: Only a low-to-high transition acts. A strobe held high for several clocks performs exactly one action.
- R13: Two instances chained through `casc_out` into `ser_in`, sharing both strobes, behave as one 16-stage register. The first eight bits shifted end up in the downstream instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Shift strobe; acts on its rising transition |
| store_clk | input | 1 | Store strobe; acts on its rising transition |
| clr_n | input | 1 | Active-low clear of the shift stages |
| oe_n | input | 1 | Active-low enable of the parallel outputs |
| par_q | output | W | Stored word (zero while disabled) |
| par_en | output | W | Per-bit drive enable for the pad ring |
| casc_out | output | 1 | Cascade bit from the last shift stage |

## Verification
A strobe rise that the bench raises at a falling clock edge is seen at the next rising edge. The stages and the storage register update at that same edge, so shift and store results are due one system clock after the strobe goes high. The bench samples them at the following falling edge. The clear's effect on `casc_out` and the output enable's effect on `par_q`/`par_en` are combinational, so those are checked 1 ns after the input changes, before any clock edge. Every other effect of the clear is checked only after a full clock has passed.

// File: rtl/lsr_pkg.sv
// Shared types for the latched shift register.
// Assumes nothing beyond IEEE 1800-2017.
package lsr_pkg;
    // Per-clock action taken by the shift chain.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_CLEAR = 2'd2
    } stage_op_e;
endpackage

// File: rtl/lsr_edge_det.sv
// Rising-transition detector for N level strobes sampled on clk.
// Assumes the strobes are synchronous to clk. After reset the previous
// level reads high, so a strobe already high at reset does not fire.
module lsr_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    // Remember last sampled level of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    // A rise is a high sample following a low one.
    always_comb rise = lvl & ~prev_q;
endmodule

// File: rtl/lsr_shift_chain.sv
// W-stage shift chain. Serial data enters stage 0. Clear has priority
// over shift. Assumes shift_en is a single-cycle pulse.
module lsr_shift_chain
    import lsr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic [W-1:0] stages
);
    stage_op_e op;

    // Decode this cycle's action; clear wins over shift.
    always_comb begin
        if (!clr_n)        op = OP_CLEAR;
        else if (shift_en) op = OP_SHIFT;
        else               op = OP_HOLD;
    end

    for (genvar g = 0; g < W; g++) begin : g_stage
        logic src;
        if (g == 0) begin : g_head
            always_comb src = ser_in;
        end else begin : g_body
            always_comb src = stages[g-1];
        end

        // One flop per stage, loaded from its upstream neighbour.
        always_ff @(posedge clk) begin
            if (!rst_n) stages[g] <= 1'b0;
            else begin
                case (op)
                    OP_CLEAR: stages[g] <= 1'b0;
                    OP_SHIFT: stages[g] <= src;
                    default:  stages[g] <= stages[g];
                endcase
            end
        end
    end
endmodule

// File: rtl/lsr_store_reg.sv
// Storage register that copies the shift chain on a load pulse.
// While the clear is asserted it loads zeros, because the chain is
// being emptied in that same cycle.
module lsr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clr_n,
    input  logic [W-1:0] stages,
    output logic [W-1:0] store_q
);
    logic [W-1:0] load_val;

    // Value seen by the storage register if it loads now.
    always_comb load_val = clr_n ? stages : '0;

    // Capture on load, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    store_q <= '0;
        else if (load) store_q <= load_val;
    end
endmodule

// File: rtl/lsr_out_drv.sv
// Parallel output stage. It gives per-bit drive enables for the pad
// ring and parks the data at zero while disabled. Purely combinational.
module lsr_out_drv #(
    parameter int W = 8
) (
    input  logic         oe_n,
    input  logic [W-1:0] store_q,
    output logic [W-1:0] par_q,
    output logic [W-1:0] par_en
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        // Gate one output bit by the enable.
        always_comb begin
            par_en[g] = ~oe_n;
            par_q[g]  = store_q[g] & ~oe_n;
        end
    end
endmodule

// File: rtl/ser_latch_sreg.sv
// Top level: serial-in shift chain, storage register and parallel
// output stage, with a cascade tap. All inputs are assumed to be
// synchronous to clk. Strobes act on their low-to-high transitions.
module ser_latch_sreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    input  logic         shift_clk,
    input  logic         store_clk,
    input  logic         clr_n,
    input  logic         oe_n,
    output logic [W-1:0] par_q,
    output logic [W-1:0] par_en,
    output logic         casc_out
);
    localparam int NSTROBE = 2;

    logic [NSTROBE-1:0] strobe_rise;
    logic               shift_rise;
    logic               store_rise;
    logic [W-1:0]       stages;
    logic [W-1:0]       store_q;

    lsr_edge_det #(.N(NSTROBE)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({store_clk, shift_clk}),
        .rise  (strobe_rise)
    );

    // Split the detected rises.
    always_comb begin
        shift_rise = strobe_rise[0];
        store_rise = strobe_rise[1];
    end

    lsr_shift_chain #(.W(W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .shift_en (shift_rise),
        .ser_in   (ser_in),
        .stages   (stages)
    );

    lsr_store_reg #(.W(W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (store_rise),
        .clr_n   (clr_n),
        .stages  (stages),
        .store_q (store_q)
    );

    lsr_out_drv #(.W(W)) u_out (
        .oe_n    (oe_n),
        .store_q (store_q),
        .par_q   (par_q),
        .par_en  (par_en)
    );

    // Cascade tap, forced low at once while clearing.
    always_comb casc_out = stages[W-1] & clr_n;
endmodule

// File: rtl/lsr_sva.sv
// Property checker for ser_latch_sreg, attached by bind below.
module lsr_sva #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ser_in,
    input logic         clr_n,
    input logic         oe_n,
    input logic         shift_rise,
    input logic         store_rise,
    input logic [W-1:0] stages,
    input logic [W-1:0] store_q,
    input logic [W-1:0] par_q,
    input logic         casc_out
);
    assert_shift_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_rise && clr_n) |=> stages == {$past(stages[W-2:0]), $past(ser_in)});

    assert_store_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (store_rise && clr_n) |=> store_q == $past(stages));

    assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> stages == '0);

    assert_clear_cascade_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> !casc_out);

    assert_clear_store_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (store_rise && !clr_n) |=> store_q == '0);

    assert_oe_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> par_q == store_q);

    assert_oe_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> par_q == '0);

    assert_cascade_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_n |-> casc_out == stages[W-1]);

    assert_store_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !store_rise |=> $stable(store_q));

    assert_shift_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !shift_rise) |=> $stable(stages));

    assert_single_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        shift_rise |=> !shift_rise);
endmodule

bind ser_latch_sreg lsr_sva #(.W(W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_in     (ser_in),
    .clr_n      (clr_n),
    .oe_n       (oe_n),
    .shift_rise (shift_rise),
    .store_rise (store_rise),
    .stages     (stages),
    .store_q    (store_q),
    .par_q      (par_q),
    .casc_out   (casc_out)
);

// File: tb/tb_ser_latch_sreg.sv
`timescale 1ns/1ps
module tb_ser_latch_sreg;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0;
    logic shift_clk = 1'b0;
    logic store_clk = 1'b0;
    logic clr_n = 1'b1;
    logic oe_n = 1'b0;
    logic [W-1:0] par_q, par_en, par_q_b, par_en_b;
    logic casc_out, casc_b;

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0] model;

    always #2.5 clk = ~clk;

    ser_latch_sreg #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
        .store_clk(store_clk), .clr_n(clr_n), .oe_n(oe_n),
        .par_q(par_q), .par_en(par_en), .casc_out(casc_out)
    );

    ser_latch_sreg #(.W(W)) dut_b (
        .clk(clk), .rst_n(rst_n), .ser_in(casc_out), .shift_clk(shift_clk),
        .store_clk(store_clk), .clr_n(clr_n), .oe_n(oe_n),
        .par_q(par_q_b), .par_en(par_en_b), .casc_out(casc_b)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk); ser_in = b; shift_clk = 1'b1;
        @(negedge clk); shift_clk = 1'b0;
        if (clr_n) model = {model[W-2:0], b};
    endtask

    task automatic shift_byte(input logic [W-1:0] v);
        for (int i = W-1; i >= 0; i--) shift_bit(v[i]);
    endtask

    task automatic store_pulse();
        @(negedge clk); store_clk = 1'b1;
        @(negedge clk); store_clk = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 par_q after reset", par_q, 8'h00);
        chk("R6 par_en enabled", par_en, 8'hFF);
        store_pulse();
        chk("R11 stages zero after reset", par_q, 8'h00);
    endtask

    task automatic t_byte();
        shift_byte(8'hA5);
        chk("R10 shift alone leaves outputs", par_q, 8'h00);
        store_pulse();
        chk("R1 R2 byte readback", par_q, 8'hA5);
        chk("R7 cascade is last stage", {7'd0, casc_out}, 8'h01);
    endtask

    task automatic t_cascade_oe();
        shift_bit(1'b1);
        chk("R7 cascade shows old stage 6", {7'd0, casc_out}, 8'h00);
        @(negedge clk); oe_n = 1'b1; #1;
        chk("R6 par_q parked", par_q, 8'h00);
        chk("R6 par_en off", par_en, 8'h00);
        chk("R7 cascade ignores oe", {7'd0, casc_out}, 8'h00);
        @(negedge clk); oe_n = 1'b0; #1;
        chk("R6 par_q returns", par_q, 8'hA5);
    endtask

    task automatic t_store_only();
        store_pulse();
        store_pulse();
        chk("R10 store keeps shift contents", par_q, model);
        shift_bit(1'b0);
        chk("R10 shift alone leaves outputs", par_q, 8'h4B);
    endtask

    task automatic t_held_level();
        store_pulse();
        @(negedge clk); ser_in = 1'b1; shift_clk = 1'b1;
        repeat (4) @(negedge clk);
        shift_clk = 1'b0;
        model = {model[W-2:0], 1'b1};
        store_pulse();
        chk("R12 held strobe shifts once", par_q, model);
    endtask

    task automatic t_clear();
        shift_byte(8'h3C);
        store_pulse();
        @(negedge clk); clr_n = 1'b0; #1;
        chk("R4 cascade low during clear", {7'd0, casc_out}, 8'h00);
        @(negedge clk);
        chk("R3 storage kept during clear", par_q, 8'h3C);
        shift_bit(1'b1);
        @(negedge clk); clr_n = 1'b1;
        model = '0;
        store_pulse();
        chk("R9 shift during clear ignored", par_q, 8'h00);
        chk("R3 stages emptied", par_q, model);
    endtask

    task automatic t_store_in_clear();
        shift_byte(8'hFF);
        store_pulse();
        chk("R2 all ones", par_q, 8'hFF);
        @(negedge clk); clr_n = 1'b0;
        store_pulse();
        chk("R5 store during clear loads zero", par_q, 8'h00);
        @(negedge clk); clr_n = 1'b1;
        model = '0;
    endtask

    task automatic t_simultaneous();
        shift_byte(8'h0F);
        @(negedge clk); ser_in = 1'b1; shift_clk = 1'b1; store_clk = 1'b1;
        @(negedge clk); shift_clk = 1'b0; store_clk = 1'b0;
        chk("R8 store lags shift", par_q, 8'h0F);
        model = {model[W-2:0], 1'b1};
        store_pulse();
        chk("R8 shifted value next store", par_q, 8'h1F);
    endtask

    task automatic t_chain();
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        for (int i = 15; i >= 0; i--) shift_bit(16'hBEEF >> i);
        store_pulse();
        chk("R13 near device low byte", par_q, 8'hEF);
        chk("R13 far device high byte", par_q_b, 8'hBE);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_fail++;
        $display("FAIL timeout on all R checks actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte();
        t_cascade_oe();
        t_store_only();
        t_held_level();
        t_clear();
        t_store_in_clear();
        t_simultaneous();
        t_chain();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule